// File: doc/BRIEF.md
# Multi-Position Unsigned Right Shifter

This block is the shift-and-flag stage of a 20-bit register datapath. It moves an operand right by one to four bit positions, filling with zeros from the top, so the result is the operand divided by 2, 4, 8 or 16 with the remainder dropped. It works in one of two widths. In address mode it shifts all 20 bits. In word mode it keeps only the low 16 bits, and the upper four bits of the result are zero.

A request strobe captures the operand, the count code and the width select. One clock later the result and the four status flags (negative, zero, carry, overflow) appear together with a one-cycle valid pulse. They keep their values until the next request. The carry flag takes the last bit that was shifted out. The overflow flag is always cleared.

Top module: `shr_unit`

## Requirements
- R1: A synchronous active-high reset clears the result, all four flags and the valid output to zero.
- R2: When `req_i` is high at a clock edge, `valid_o` is high for exactly the following cycle, and the result and flags take their new values in that same cycle. When no request arrives, the result and flags hold their previous values.
- R3: The 2-bit count code `cnt_code_i` selects a shift of code+1 positions: 00 means 1 position and 11 means 4 positions.
- R4: In address mode (`word_mode_i` = 0), the result is the 20-bit operand shifted right logically by n positions, with zeros entering at bit 19.
- R5: The carry flag equals bit n-1 of the operand that is shifted, which is the last bit shifted out.
- R6: In word mode (`word_mode_i` = 1), result bits 19:16 are zero and result bits 15:0 are operand bits 15:0 shifted right by n, with zeros entering at bit 15.
- R7: In word mode, operand bits 19:16 affect neither the result nor any flag.
- R8: The negative flag is result bit 19 in address mode and result bit 15 in word mode.
- R9: The zero flag is set exactly when the whole 20-bit result is zero.
- R10: The overflow flag is zero after every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe; captures the inputs below |
| operand_i | input | 20 | Value to shift |
| cnt_code_i | input | 2 | Shift count code; shift = code + 1 |
| word_mode_i | input | 1 | 1 = 16-bit word mode, 0 = 20-bit address mode |
| result_o | output | 20 | Shifted result |
| valid_o | output | 1 | One-cycle pulse when a new result is present |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The hardest case to reach is a word-mode operation where every retained bit is shifted out while ones remain in the discarded upper nibble. The zero flag must then be set, and the carry must come only from the low half. To reach it, the bench drives operands such as 0xF0008 with a four-position shift, so a one lands in the carry and the result is zero. It also repeats word-mode operations with identical low halves and different upper nibbles, and compares the two sets of outputs directly.

// File: rtl/shr_pkg.sv
package shr_pkg;

    localparam int SHR_DATA_W = 20;
    localparam int SHR_WORD_W = 16;
    localparam int SHR_CNT_W  = 2;

    typedef enum logic {
        SHR_ADDR = 1'b0,
        SHR_WORD = 1'b1
    } shr_width_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } shr_flags_t;

    localparam shr_flags_t SHR_FLAGS_CLR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    function automatic int unsigned shr_amount(input logic [SHR_CNT_W-1:0] code);
        return int'(code) + 1;
    endfunction

endpackage

// File: rtl/shr_width_mask.sv
module shr_width_mask #(
    parameter int DATA_W = shr_pkg::SHR_DATA_W,
    parameter int WORD_W = shr_pkg::SHR_WORD_W
) (
    input  logic                  word_mode,
    input  logic [DATA_W-1:0]     value_in,
    output logic [DATA_W-1:0]     value_out
);
    localparam int HI_W = DATA_W - WORD_W;

    generate
        if (HI_W > 0) begin : g_has_hi
            always_comb begin
                value_out = value_in;
                if (word_mode == shr_pkg::SHR_WORD)
                    value_out[DATA_W-1:WORD_W] = '0;
            end
        end else begin : g_no_hi
            assign value_out = value_in;
        end
    endgenerate
endmodule

// File: rtl/shr_stage_chain.sv
module shr_stage_chain #(
    parameter int DATA_W = shr_pkg::SHR_DATA_W,
    parameter int CNT_W  = shr_pkg::SHR_CNT_W
) (
    input  logic [DATA_W-1:0] value_in,
    input  logic [CNT_W-1:0]  code,
    output logic [DATA_W-1:0] value_out,
    output logic              last_out
);
    // Stages move by code (= n-1); a final fixed step of one gives n.
    logic [DATA_W-1:0] stg [CNT_W+1];

    assign stg[0] = value_in;

    generate
        for (genvar s = 0; s < CNT_W; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stg[s+1] = code[s] ? (stg[s] >> SH) : stg[s];
        end
    endgenerate

    assign last_out  = stg[CNT_W][0];
    assign value_out = stg[CNT_W] >> 1;
endmodule

// File: rtl/shr_flag_gen.sv
module shr_flag_gen #(
    parameter int DATA_W = shr_pkg::SHR_DATA_W,
    parameter int WORD_W = shr_pkg::SHR_WORD_W
) (
    input  logic                 word_mode,
    input  logic [DATA_W-1:0]    result,
    input  logic                 carry_in,
    output shr_pkg::shr_flags_t  flags
);
    always_comb begin
        flags   = shr_pkg::SHR_FLAGS_CLR;
        flags.n = (word_mode == shr_pkg::SHR_WORD) ? result[WORD_W-1] : result[DATA_W-1];
        flags.z = (result == '0);
        flags.c = carry_in;
        flags.v = 1'b0;
    end
endmodule

// File: rtl/shr_unit.sv
module shr_unit #(
    parameter int DATA_W = shr_pkg::SHR_DATA_W,
    parameter int WORD_W = shr_pkg::SHR_WORD_W,
    parameter int CNT_W  = shr_pkg::SHR_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  cnt_code_i,
    input  logic              word_mode_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic              flag_v_o
);
    import shr_pkg::*;

    logic [DATA_W-1:0] masked_w;
    logic [DATA_W-1:0] shifted_w;
    logic              carry_w;
    shr_flags_t        flags_w;

    logic [DATA_W-1:0] res_q;
    shr_flags_t        flags_q;
    logic              valid_q;

    shr_width_mask #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_mask (
        .word_mode (word_mode_i),
        .value_in  (operand_i),
        .value_out (masked_w)
    );

    shr_stage_chain #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chain (
        .value_in  (masked_w),
        .code      (cnt_code_i),
        .value_out (shifted_w),
        .last_out  (carry_w)
    );

    shr_flag_gen #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_flags (
        .word_mode (word_mode_i),
        .result    (shifted_w),
        .carry_in  (carry_w),
        .flags     (flags_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= SHR_FLAGS_CLR;
            valid_q <= 1'b0;
        end else begin
            valid_q <= req_i;
            if (req_i) begin
                res_q   <= shifted_w;
                flags_q <= flags_w;
            end
        end
    end

    assign result_o = res_q;
    assign valid_o  = valid_q;
    assign flag_n_o = flags_q.n;
    assign flag_z_o = flags_q.z;
    assign flag_c_o = flags_q.c;
    assign flag_v_o = flags_q.v;

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o);

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !valid_o);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> ($stable(result_o) && $stable(flag_c_o) && $stable(flag_z_o)));

    // R4
    no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> (result_o <= ($past(operand_i) >> 1)));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (flag_z_o == (result_o == '0)));

    // R6
    generate
        if (DATA_W > WORD_W) begin : g_word_chk
            word_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (req_i && word_mode_i) |=> (result_o[DATA_W-1:WORD_W] == '0));
        end
    endgenerate

    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !flag_v_o);
endmodule

// File: tb/shr_unit_tb_top.sv
module shr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [19:0] operand_i;
    logic [1:0]  cnt_code_i;
    logic        word_mode_i;
    logic [19:0] result_o;
    logic        valid_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    shr_unit dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .operand_i(operand_i),
        .cnt_code_i(cnt_code_i), .word_mode_i(word_mode_i),
        .result_o(result_o), .valid_o(valid_o), .flag_n_o(flag_n_o),
        .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model: returns {n,z,c,v,result}
    function automatic logic [23:0] model(input logic [19:0] op, input logic [1:0] code, input logic wm);
        logic [19:0] src;
        logic [19:0] res;
        int n;
        logic c, nf, zf;
        n   = code + 1;
        src = wm ? {4'h0, op[15:0]} : op;
        res = src >> n;
        c   = src[n-1];
        nf  = wm ? res[15] : res[19];
        zf  = (res == 20'h0);
        return {nf, zf, c, 1'b0, res};
    endfunction

    task automatic issue(input logic [19:0] op, input logic [1:0] code, input logic wm);
        @(negedge clk);
        req_i = 1'b1; operand_i = op; cnt_code_i = code; word_mode_i = wm;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [19:0] op, input logic [1:0] code, input logic wm);
        logic [23:0] e;
        e = model(op, code, wm);
        issue(op, code, wm);
        check({req, " result"}, result_o, e[19:0]);
        check({req, " R5 carry"}, flag_c_o, e[21]);
        check({req, " R8 neg"}, flag_n_o, e[23]);
        check({req, " R9 zero"}, flag_z_o, e[22]);
        check({req, " R10 ovf"}, flag_v_o, 1'b0);
        check({req, " R2 valid"}, valid_o, 1'b1);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_i = 1'b0; operand_i = '0; cnt_code_i = '0; word_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 result", result_o, 0);
        check("R1 valid", valid_o, 0);
        check("R1 flags", {flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 0);
        rst = 1'b0;
    endtask

    task automatic t_addr_counts();
        for (int k = 0; k < 4; k++) begin
            run_op("R3 R4 addr", 20'hFFFFF, k[1:0], 1'b0);
            run_op("R3 R4 addr", 20'hA5C3B, k[1:0], 1'b0);
            run_op("R3 R5 addr", 20'h80001 << k, k[1:0], 1'b0);
        end
        issue(20'h12345, 2'b11, 1'b0);
        check("R3 R4 n=4 divide", result_o, 20'h01234);
    endtask

    task automatic t_word_mode();
        for (int k = 0; k < 4; k++) begin
            run_op("R6 word", 20'h0FFFF, k[1:0], 1'b1);
            run_op("R6 word", 20'hFB7E9, k[1:0], 1'b1);
        end
        issue(20'hF8000, 2'b00, 1'b1);
        check("R6 word zero into bit15", result_o, 20'h04000);
    endtask

    task automatic t_upper_ignored();
        logic [19:0] r0;
        logic [3:0]  f0;
        for (int k = 0; k < 4; k++) begin
            issue(20'h0_5A3F, k[1:0], 1'b1);
            r0 = result_o; f0 = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
            issue(20'hE_5A3F, k[1:0], 1'b1);
            check("R7 result vs upper", result_o, r0);
            check("R7 flags vs upper", {flag_n_o, flag_z_o, flag_c_o, flag_v_o}, f0);
        end
        // all kept bits shifted out, upper nibble set: zero with carry
        run_op("R7 R9 zero-with-carry", 20'hF0008, 2'b11, 1'b1);
        check("R9 zero flag set", flag_z_o, 1'b1);
        check("R5 carry from bit3", flag_c_o, 1'b1);
        run_op("R9 addr nonzero upper", 20'hF0008, 2'b11, 1'b0);
    endtask

    task automatic t_valid_hold();
        logic [19:0] r0;
        issue(20'h3C3C3, 2'b01, 1'b0);
        r0 = result_o;
        @(negedge clk);
        check("R2 valid single pulse", valid_o, 1'b0);
        operand_i = 20'h00000; cnt_code_i = 2'b11; word_mode_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 hold result", result_o, r0);
        check("R2 hold zero flag", flag_z_o, 1'b0);
        check("R2 still idle", valid_o, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_addr_counts();
                t_word_mode();
                t_upper_ignored();
                t_valid_hold();
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule